// File: doc/BRIEF.md
# Store-to-Load Overlap and Forwarding Checker

Before a load is allowed to issue, this block compares the load's byte range with every older store that could still supply or corrupt its value. Two groups of stores are examined: the stores still waiting in the memory queue, and, when the relaxed (release-consistency) ordering mode is on, the stores that have already left the queue for the post-issue store buffer. Each byte range is an address plus a size code (1, 2, 4 or 8 bytes). Each store also carries an age tag, so the block can tell which stores are older than the load and which of those is the youngest.

The block returns one of three verdicts: clear to issue, forward, or stall. A forward carries the store's data, the group it came from and its slot index. A forward is only taken when the store and the load cover exactly the same bytes. Any partial overlap stalls the load, and so does an older queue store whose address is not yet known. A value forwarded from the post-issue buffer still sends the load to the cache. A value forwarded from the queue does not.

The overlap test runs over all entries in parallel. The verdict is registered, so it appears at the outputs one clock edge after the query.

Top module: `stl_fwd_check`

## Requirements
- R1: While rst_ni is low, res_o is 2'b00, cache_issue_o is 0 and fwd_data_o, fwd_src_sb_o and fwd_idx_o are all zero.
- R2: A queue store counts only if it is older than the load. It is older when (ld_age_i - store age) modulo 2^AGE_W is nonzero and has its top bit clear. Stores with an equal or younger age are ignored.
- R3: Size code c covers 2^c bytes starting at the address. If the deciding store is a queue store with a known address, the same address and the same size code, the result is forward (res_o = 2'b01): fwd_data_o is its data, fwd_src_sb_o is 0, fwd_idx_o is its slot and cache_issue_o is 0.
- R4: If the deciding store's byte range intersects the load's range without matching it exactly, the result is stall (res_o = 2'b10). In that case cache_issue_o is 0 and the forward fields are zero. Ranges are compared without wrapping at the top of the address space.
- R5: An older valid queue store whose address is not yet known (q_addr_known_i bit low) counts as overlapping, whatever its address field holds. When it decides the result, the result is stall.
- R6: Of all the stores that count, the youngest one decides the result. The youngest is the store with the smallest age distance to the load. Older matches hidden behind it have no effect.
- R7: Post-issue buffer entries are examined only while rc_mode_i is 1. Every valid buffer entry counts as older than the load and older than every queue store. A buffer entry therefore decides only when no queue store counts.
- R8: An exact match with the deciding buffer entry gives forward, with fwd_src_sb_o 1, the entry's data and slot, and cache_issue_o 1.
- R9: A partial overlap with the deciding buffer entry gives stall.
- R10: When a valid load has no store that counts, the result is clear (res_o = 2'b00) with cache_issue_o 1. Byte ranges that only touch end to end do not overlap.
- R11: While ld_valid_i is 0, the result is clear with cache_issue_o 0 and all forward fields zero.
- R12: The verdict for the inputs present before a rising clock edge appears on the outputs after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rc_mode_i | input | 1 | Relaxed ordering mode; enables the post-issue buffer check |
| ld_valid_i | input | 1 | A load query is present |
| ld_addr_i | input | AW | Load byte address |
| ld_size_i | input | 2 | Load size code (2^code bytes) |
| ld_age_i | input | AGE_W | Load age tag |
| q_valid_i | input | QD | Queue slot holds a store |
| q_addr_known_i | input | QD | Queue store address has been generated |
| q_addr_i | input | QD*AW | Queue store addresses, slot i at bits [i*AW +: AW] |
| q_size_i | input | QD*2 | Queue store size codes |
| q_age_i | input | QD*AGE_W | Queue store age tags |
| q_data_i | input | QD*DW | Queue store data |
| sb_valid_i | input | SD | Post-issue buffer slot valid |
| sb_addr_i | input | SD*AW | Buffer store addresses |
| sb_size_i | input | SD*2 | Buffer store size codes |
| sb_age_i | input | SD*AGE_W | Buffer store age tags |
| sb_data_i | input | SD*DW | Buffer store data |
| res_o | output | 2 | Verdict: 00 clear, 01 forward, 10 stall |
| fwd_data_o | output | DW | Forwarded store data |
| fwd_src_sb_o | output | 1 | Forward came from the post-issue buffer |
| fwd_idx_o | output | IDX_W | Slot index of the forwarding store |
| cache_issue_o | output | 1 | Load is to be sent to the cache |

## Verification
A wrong youngest-store choice or a broken age comparison shows at the ports one edge after the query. It appears either as the wrong verdict or as a forward with the wrong data or index, so it is caught on the very cycle the query is answered. A fault in the group or mode gating shows as a buffer forward while rc_mode_i is low, or as a wrong cache_issue_o with a forward. The reference model recomputes every cycle's verdict from the raw ranges and ages, so a divergence is flagged on the first query that exposes it.

// File: rtl/stl_fwd_pkg.sv
package stl_fwd_pkg;
  typedef enum logic [1:0] {
    RES_CLEAR = 2'b00,
    RES_FWD   = 2'b01,
    RES_STALL = 2'b10
  } chk_res_e;

  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/stl_range_cmp.sv
module stl_range_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a_addr_i,
  input  logic [1:0]    a_size_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [1:0]    b_size_i,
  output logic          overlap_o,
  output logic          exact_o
);
  import stl_fwd_pkg::*;
  localparam int EW = AW + 1;

  logic [EW-1:0] a_beg, b_beg, a_end, b_end;

  // one extra bit so ranges near the top do not wrap
  always_comb begin
    a_beg = {1'b0, a_addr_i};
    b_beg = {1'b0, b_addr_i};
    a_end = a_beg + EW'(size_bytes(a_size_i));
    b_end = b_beg + EW'(size_bytes(b_size_i));
  end

  assign overlap_o = (a_beg < b_end) && (b_beg < a_end);
  assign exact_o   = (a_addr_i == b_addr_i) && (a_size_i == b_size_i);
endmodule

// File: rtl/stl_young_pick.sv
module stl_young_pick #(
  parameter int N     = 8,
  parameter int AGE_W = 5,
  parameter int IW    = $clog2(N)
) (
  input  logic [N-1:0]       hit_i,
  input  logic [N*AGE_W-1:0] dist_i,
  output logic               found_o,
  output logic [IW-1:0]      idx_o
);
  logic [AGE_W-1:0] best;

  // smallest age distance = youngest older store
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && (!found_o || dist_i[i*AGE_W +: AGE_W] < best)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        best    = dist_i[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/stl_fwd_check.sv
module stl_fwd_check #(
  parameter int QD    = 8,
  parameter int SD    = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int AGE_W = 5,
  localparam int QIW   = $clog2(QD),
  localparam int SIW   = $clog2(SD),
  localparam int IDX_W = (QIW > SIW) ? QIW : SIW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rc_mode_i,
  input  logic                ld_valid_i,
  input  logic [AW-1:0]       ld_addr_i,
  input  logic [1:0]          ld_size_i,
  input  logic [AGE_W-1:0]    ld_age_i,
  input  logic [QD-1:0]       q_valid_i,
  input  logic [QD-1:0]       q_addr_known_i,
  input  logic [QD*AW-1:0]    q_addr_i,
  input  logic [QD*2-1:0]     q_size_i,
  input  logic [QD*AGE_W-1:0] q_age_i,
  input  logic [QD*DW-1:0]    q_data_i,
  input  logic [SD-1:0]       sb_valid_i,
  input  logic [SD*AW-1:0]    sb_addr_i,
  input  logic [SD*2-1:0]     sb_size_i,
  input  logic [SD*AGE_W-1:0] sb_age_i,
  input  logic [SD*DW-1:0]    sb_data_i,
  output logic [1:0]          res_o,
  output logic [DW-1:0]       fwd_data_o,
  output logic                fwd_src_sb_o,
  output logic [IDX_W-1:0]    fwd_idx_o,
  output logic                cache_issue_o
);
  import stl_fwd_pkg::*;

  logic [QD-1:0]       q_hit, q_exact;
  logic [QD*AGE_W-1:0] q_dist;
  logic [DW-1:0]       q_data_a [QD];
  logic [SD-1:0]       s_hit, s_exact;
  logic [SD*AGE_W-1:0] s_dist;
  logic [DW-1:0]       s_data_a [SD];

  for (genvar i = 0; i < QD; i++) begin : g_q
    logic ov, ex, older;
    logic [AGE_W-1:0] d;
    stl_range_cmp #(.AW(AW)) u_cmp (
      .a_addr_i (ld_addr_i),
      .a_size_i (ld_size_i),
      .b_addr_i (q_addr_i[i*AW +: AW]),
      .b_size_i (q_size_i[i*2 +: 2]),
      .overlap_o(ov),
      .exact_o  (ex)
    );
    assign d     = ld_age_i - q_age_i[i*AGE_W +: AGE_W];
    assign older = (d != '0) && !d[AGE_W-1];
    // unknown address counts as a possible overlap
    assign q_hit[i]   = q_valid_i[i] && older && (!q_addr_known_i[i] || ov);
    assign q_exact[i] = q_addr_known_i[i] && ex;
    assign q_dist[i*AGE_W +: AGE_W] = d;
    assign q_data_a[i] = q_data_i[i*DW +: DW];
  end

  for (genvar j = 0; j < SD; j++) begin : g_sb
    logic ov, ex;
    stl_range_cmp #(.AW(AW)) u_cmp (
      .a_addr_i (ld_addr_i),
      .a_size_i (ld_size_i),
      .b_addr_i (sb_addr_i[j*AW +: AW]),
      .b_size_i (sb_size_i[j*2 +: 2]),
      .overlap_o(ov),
      .exact_o  (ex)
    );
    assign s_hit[j]   = rc_mode_i && sb_valid_i[j] && ov;
    assign s_exact[j] = ex;
    assign s_dist[j*AGE_W +: AGE_W] = ld_age_i - sb_age_i[j*AGE_W +: AGE_W];
    assign s_data_a[j] = sb_data_i[j*DW +: DW];
  end

  logic           q_found, s_found;
  logic [QIW-1:0] q_idx;
  logic [SIW-1:0] s_idx;

  stl_young_pick #(.N(QD), .AGE_W(AGE_W), .IW(QIW)) u_qpick (
    .hit_i  (q_hit),
    .dist_i (q_dist),
    .found_o(q_found),
    .idx_o  (q_idx)
  );

  stl_young_pick #(.N(SD), .AGE_W(AGE_W), .IW(SIW)) u_spick (
    .hit_i  (s_hit),
    .dist_i (s_dist),
    .found_o(s_found),
    .idx_o  (s_idx)
  );

  chk_res_e         n_res;
  logic [DW-1:0]    n_data;
  logic             n_sb, n_ci;
  logic [IDX_W-1:0] n_idx;

  // queue stores are always younger than buffer stores, so queue decides first
  always_comb begin
    n_res  = RES_CLEAR;
    n_data = '0;
    n_sb   = 1'b0;
    n_idx  = '0;
    n_ci   = 1'b0;
    if (ld_valid_i) begin
      if (q_found) begin
        if (q_exact[q_idx]) begin
          n_res  = RES_FWD;
          n_data = q_data_a[q_idx];
          n_idx  = IDX_W'(q_idx);
        end else begin
          n_res = RES_STALL;
        end
      end else if (s_found) begin
        if (s_exact[s_idx]) begin
          n_res  = RES_FWD;
          n_data = s_data_a[s_idx];
          n_sb   = 1'b1;
          n_idx  = IDX_W'(s_idx);
          n_ci   = 1'b1;
        end else begin
          n_res = RES_STALL;
        end
      end else begin
        n_ci = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o         <= RES_CLEAR;
      fwd_data_o    <= '0;
      fwd_src_sb_o  <= 1'b0;
      fwd_idx_o     <= '0;
      cache_issue_o <= 1'b0;
    end else begin
      res_o         <= n_res;
      fwd_data_o    <= n_data;
      fwd_src_sb_o  <= n_sb;
      fwd_idx_o     <= n_idx;
      cache_issue_o <= n_ci;
    end
  end
endmodule

// File: rtl/stl_fwd_check_sva.sv
module stl_fwd_check_sva #(
  parameter int QD    = 8,
  parameter int SD    = 4,
  parameter int DW    = 64,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rc_mode_i,
  input logic             ld_valid_i,
  input logic [QD-1:0]    q_valid_i,
  input logic [SD-1:0]    sb_valid_i,
  input logic [1:0]       res_o,
  input logic [DW-1:0]    fwd_data_o,
  input logic             fwd_src_sb_o,
  input logic [IDX_W-1:0] fwd_idx_o,
  input logic             cache_issue_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(ld_valid_i) |-> (res_o == 2'b00 && !cache_issue_o && !fwd_src_sb_o &&
                            fwd_data_o == '0 && fwd_idx_o == '0));

  a_r7_no_sb_outside_rc: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(rc_mode_i) |-> !fwd_src_sb_o);

  a_r8_sb_fwd_to_cache: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (res_o == 2'b01 && fwd_src_sb_o) |-> cache_issue_o);

  a_r3_q_fwd_no_cache: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (res_o == 2'b01 && !fwd_src_sb_o) |-> !cache_issue_o);

  a_r4_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    (res_o == 2'b10) |-> (!cache_issue_o && fwd_data_o == '0 && !fwd_src_sb_o));

  a_r10_empty_clear: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(ld_valid_i && q_valid_i == '0 && (!rc_mode_i || sb_valid_i == '0))
      |-> (res_o == 2'b00 && cache_issue_o));

  a_r12_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(ld_valid_i) |-> (res_o != 2'b11 && (res_o != 2'b00 || cache_issue_o)));
endmodule

bind stl_fwd_check stl_fwd_check_sva #(
  .QD(QD), .SD(SD), .DW(DW), .IDX_W(IDX_W)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rc_mode_i    (rc_mode_i),
  .ld_valid_i   (ld_valid_i),
  .q_valid_i    (q_valid_i),
  .sb_valid_i   (sb_valid_i),
  .res_o        (res_o),
  .fwd_data_o   (fwd_data_o),
  .fwd_src_sb_o (fwd_src_sb_o),
  .fwd_idx_o    (fwd_idx_o),
  .cache_issue_o(cache_issue_o)
);

// File: tb/sim_stl_fwd_check.sv
`timescale 1ns/1ps
module sim_stl_fwd_check;
  localparam int QD = 8, SD = 4, AW = 32, DW = 64, AGE_W = 5, IDX_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic rc_mode, ld_valid;
  logic [AW-1:0] ld_addr;
  logic [1:0] ld_size;
  logic [AGE_W-1:0] ld_age;

  logic tq_v [QD], tq_k [QD];
  logic [AW-1:0] tq_a [QD];
  logic [1:0] tq_s [QD];
  logic [AGE_W-1:0] tq_g [QD];
  logic [DW-1:0] tq_d [QD];
  logic ts_v [SD];
  logic [AW-1:0] ts_a [SD];
  logic [1:0] ts_s [SD];
  logic [AGE_W-1:0] ts_g [SD];
  logic [DW-1:0] ts_d [SD];

  logic [QD-1:0] q_valid, q_known;
  logic [QD*AW-1:0] q_addr;
  logic [QD*2-1:0] q_size;
  logic [QD*AGE_W-1:0] q_age;
  logic [QD*DW-1:0] q_data;
  logic [SD-1:0] sb_valid;
  logic [SD*AW-1:0] sb_addr;
  logic [SD*2-1:0] sb_size;
  logic [SD*AGE_W-1:0] sb_age;
  logic [SD*DW-1:0] sb_data;

  always_comb begin
    for (int i = 0; i < QD; i++) begin
      q_valid[i] = tq_v[i];
      q_known[i] = tq_k[i];
      q_addr[i*AW +: AW] = tq_a[i];
      q_size[i*2 +: 2] = tq_s[i];
      q_age[i*AGE_W +: AGE_W] = tq_g[i];
      q_data[i*DW +: DW] = tq_d[i];
    end
    for (int j = 0; j < SD; j++) begin
      sb_valid[j] = ts_v[j];
      sb_addr[j*AW +: AW] = ts_a[j];
      sb_size[j*2 +: 2] = ts_s[j];
      sb_age[j*AGE_W +: AGE_W] = ts_g[j];
      sb_data[j*DW +: DW] = ts_d[j];
    end
  end

  logic [1:0] res;
  logic [DW-1:0] fdata;
  logic fsb, ci;
  logic [IDX_W-1:0] fidx;

  stl_fwd_check #(.QD(QD), .SD(SD), .AW(AW), .DW(DW), .AGE_W(AGE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rc_mode_i(rc_mode), .ld_valid_i(ld_valid),
    .ld_addr_i(ld_addr), .ld_size_i(ld_size), .ld_age_i(ld_age),
    .q_valid_i(q_valid), .q_addr_known_i(q_known), .q_addr_i(q_addr),
    .q_size_i(q_size), .q_age_i(q_age), .q_data_i(q_data),
    .sb_valid_i(sb_valid), .sb_addr_i(sb_addr), .sb_size_i(sb_size),
    .sb_age_i(sb_age), .sb_data_i(sb_data),
    .res_o(res), .fwd_data_o(fdata), .fwd_src_sb_o(fsb), .fwd_idx_o(fidx),
    .cache_issue_o(ci)
  );

  int n_cmp = 0, n_bad = 0;
  int e_res, e_sb, e_idx, e_ci;
  logic [DW-1:0] e_data;

  function automatic bit ranges_meet(longint a, int sa, longint b, int sb_);
    return (a < b + (64'd1 << sb_)) && (b < a + (64'd1 << sa));
  endfunction

  task automatic model();
    int bq = -1, bs = -1, bd = 99;
    logic [AGE_W-1:0] dd;
    e_res = 0; e_sb = 0; e_idx = 0; e_ci = 0; e_data = '0;
    if (!ld_valid) return;
    for (int i = 0; i < QD; i++) begin
      dd = ld_age - tq_g[i];
      if (tq_v[i] && dd != 0 && int'(dd) < (1 << (AGE_W-1)) &&
          (!tq_k[i] || ranges_meet(ld_addr, ld_size, tq_a[i], tq_s[i])) && int'(dd) < bd) begin
        bq = i; bd = int'(dd);
      end
    end
    if (bq >= 0) begin
      if (tq_k[bq] && tq_a[bq] == ld_addr && tq_s[bq] == ld_size) begin
        e_res = 1; e_data = tq_d[bq]; e_idx = bq;
      end else e_res = 2;
      return;
    end
    bd = 99;
    if (rc_mode)
      for (int j = 0; j < SD; j++) begin
        dd = ld_age - ts_g[j];
        if (ts_v[j] && ranges_meet(ld_addr, ld_size, ts_a[j], ts_s[j]) && int'(dd) < bd) begin
          bs = j; bd = int'(dd);
        end
      end
    if (bs >= 0) begin
      if (ts_a[bs] == ld_addr && ts_s[bs] == ld_size) begin
        e_res = 1; e_data = ts_d[bs]; e_idx = bs; e_sb = 1; e_ci = 1;
      end else e_res = 2;
    end else e_ci = 1;
  endtask

  task automatic compare(string tag);
    n_cmp++;
    if (int'(res) != e_res || fdata !== e_data || int'(fsb) != e_sb ||
        int'(fidx) != e_idx || int'(ci) != e_ci) begin
      n_bad++;
      $display("FAIL %s res=%0d/%0d data=%h/%h sb=%0d/%0d idx=%0d/%0d ci=%0d/%0d",
               tag, res, e_res, fdata, e_data, fsb, e_sb, fidx, e_idx, ci, e_ci);
    end
  endtask

  task automatic step(string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic clear_all();
    rc_mode = 0; ld_valid = 1; ld_addr = 32'h100; ld_size = 2; ld_age = 5'd10;
    for (int i = 0; i < QD; i++) begin
      tq_v[i] = 0; tq_k[i] = 1; tq_a[i] = '0; tq_s[i] = 0; tq_g[i] = '0; tq_d[i] = '0;
    end
    for (int j = 0; j < SD; j++) begin
      ts_v[j] = 0; ts_a[j] = '0; ts_s[j] = 0; ts_g[j] = '0; ts_d[j] = '0;
    end
  endtask

  task automatic qset(int i, bit k, logic [AW-1:0] a, logic [1:0] s, int rel, logic [DW-1:0] d);
    tq_v[i] = 1; tq_k[i] = k; tq_a[i] = a; tq_s[i] = s;
    tq_g[i] = ld_age + AGE_W'(rel); tq_d[i] = d;
  endtask

  task automatic sset(int j, logic [AW-1:0] a, logic [1:0] s, int rel, logic [DW-1:0] d);
    ts_v[j] = 1; ts_a[j] = a; ts_s[j] = s; ts_g[j] = ld_age + AGE_W'(rel); ts_d[j] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_all();
    ld_valid = 0;
    repeat (3) @(negedge clk);
    e_res = 0; e_data = '0; e_sb = 0; e_idx = 0; e_ci = 0;
    compare("R1 reset");
    rst_ni = 1;

    // R11: no load, even with a matching store
    clear_all(); ld_valid = 0; qset(0, 1, 32'h100, 2, -1, 64'h11); step("R11");
    // R10: nothing to compare
    clear_all(); step("R10 empty");
    // R10: touching ranges only
    clear_all(); qset(1, 1, 32'h104, 2, -1, 64'h22); qset(2, 1, 32'hFC, 2, -2, 64'h33); step("R10 adjacent");
    // R3: exact older match
    clear_all(); qset(2, 1, 32'h100, 2, -2, 64'hA5A5_0000_1234_5678); step("R3 exact");
    // R12: outputs hold until next edge
    clear_all(); #2;
    n_cmp++;
    if (res != 2'b01 || fidx != 3'd2) begin
      n_bad++; $display("FAIL R12 held res=%0d/1 idx=%0d/2", res, fidx);
    end
    step("R12 next");
    // R2: younger and equal-age stores ignored
    clear_all(); qset(1, 1, 32'h100, 2, 2, 64'h44); qset(3, 1, 32'h100, 2, 0, 64'h55); step("R2 younger");
    // R2: age wrap, store at 30 older than load at 1
    clear_all(); ld_age = 5'd1; qset(4, 1, 32'h100, 2, -3, 64'h66); step("R2 wrap");
    // R4: partial inside, wider store, top of space
    clear_all(); qset(0, 1, 32'h102, 1, -1, 64'h77); step("R4 inner");
    clear_all(); qset(0, 1, 32'h100, 3, -1, 64'h78); step("R4 wider");
    clear_all(); ld_addr = 32'hFFFF_FFF8; ld_size = 3; qset(5, 1, 32'hFFFF_FFFC, 2, -1, 64'h79); step("R4 top");
    // R5: unknown address stalls
    clear_all(); qset(6, 0, 32'h9000, 0, -4, 64'h88); step("R5 unknown");
    // R6: youngest decides
    clear_all(); qset(1, 1, 32'h100, 2, -3, 64'h99); qset(2, 1, 32'h101, 0, -1, 64'h9A); step("R6 stall wins");
    clear_all(); qset(1, 1, 32'h101, 0, -3, 64'h99); qset(7, 1, 32'h100, 2, -1, 64'h9B); step("R6 fwd wins");
    clear_all(); qset(3, 0, 32'h0, 0, -5, 64'h1); qset(4, 1, 32'h100, 2, -2, 64'h9C); step("R6 unknown shadowed");
    // R7: buffer ignored outside rc mode, queue beats buffer
    clear_all(); sset(1, 32'h100, 2, -12, 64'hB1); step("R7 off");
    clear_all(); rc_mode = 1; sset(1, 32'h100, 2, -12, 64'hB1);
    qset(0, 1, 32'h100, 2, -1, 64'hC1); step("R7 queue first");
    // R8: forward from buffer
    clear_all(); rc_mode = 1; sset(3, 32'h100, 2, -12, 64'hB3); step("R8 sb fwd");
    // R9: buffer partial, and youngest buffer partial over older exact
    clear_all(); rc_mode = 1; sset(0, 32'h102, 2, -12, 64'hB4); step("R9 sb partial");
    clear_all(); rc_mode = 1; sset(0, 32'h100, 2, -14, 64'hB5); sset(2, 32'h103, 0, -11, 64'hB6); step("R9 sb youngest");

    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 16, r2 = $urandom % 4;
      rc_mode = $urandom % 2; ld_valid = ($urandom % 8) != 0;
      ld_age = AGE_W'($urandom); ld_size = 2'($urandom);
      ld_addr = 32'h200 + ($urandom % 24);
      for (int i = 0; i < QD; i++) begin
        tq_v[i] = ($urandom % 3) == 0; tq_k[i] = ($urandom % 6) != 0;
        if ($urandom % 3 == 0) begin tq_a[i] = ld_addr; tq_s[i] = ld_size; end
        else begin tq_a[i] = 32'h200 + ($urandom % 24); tq_s[i] = 2'($urandom); end
        tq_g[i] = ld_age + AGE_W'(((i*3 + r) % 16) - 8);
        tq_d[i] = {$urandom, $urandom};
      end
      for (int j = 0; j < SD; j++) begin
        ts_v[j] = ($urandom % 2) == 0;
        if ($urandom % 3 == 0) begin ts_a[j] = ld_addr; ts_s[j] = ld_size; end
        else begin ts_a[j] = 32'h200 + ($urandom % 24); ts_s[j] = 2'($urandom); end
        ts_g[j] = ld_age - AGE_W'(9 + ((j + r2) % 4));
        ts_d[j] = {$urandom, $urandom};
      end
      step("R6 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule